// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Hardware Reload

This block turns virtual addresses into physical addresses using a small fully associative table of recent translations. Every slot holds a virtual page number as its search key. A lookup compares all slots at once. On a hit, the physical address comes back in the same cycle. It is the slot's frame number placed above the page offset, which passes through unchanged. For example, page 0x3 mapped to frame 0x45 turns address 0x3A7 into 0x45A7.

On a miss the block raises `busy` and reloads the translation itself. It reads the page-table entry at `pt_base + vpn` through a one-word request/acknowledge memory port. If that entry is not present, the block answers with a fault and changes nothing. Otherwise it picks a slot. An empty slot is used first; when every slot is occupied, a round-robin pointer names the victim. The victim's referenced and dirty flags are written back to its own page-table word before the new entry is installed. Once installed, the held request hits and is answered. A read access marks the slot referenced. A write access marks it referenced and dirty. A flush pulse empties every slot.

Top module: `xlat_buffer`

## Requirements
- R1: When idle, a request whose page is held in a slot gets `resp_valid` high in the same cycle, with `busy` low, `resp_fault` low and `resp_paddr = {frame, offset}`.
- R2: A request whose page is not held raises `busy` from the next cycle. The block reads the word at `mem_addr = pt_base + vpn` with `mem_we` low. It then answers the still-held request with the translated address.
- R3: Page-table word layout: bit 0 is present, bit 1 is referenced, bit 2 is dirty, and bits [3 +: PFN_W] hold the frame number.
- R4: A read access sets the slot's referenced flag. A write access sets both the referenced and dirty flags. Both flags are seen in the word written back on eviction.
- R5: A fetched word with present = 0 gives `resp_valid` and `resp_fault` together, and no slot is filled, so a repeat of the same request misses again.
- R6: While any slot is empty, a reload fills an empty slot and never evicts a held page.
- R7: When all slots are full, the victim is chosen round-robin starting at slot 0. Its word {frame, dirty, referenced, present=1} is written to `pt_base + victim vpn` before the new entry is installed. No write is issued when the chosen slot was empty.
- R8: A one-cycle `flush` empties every slot, so the next access to any page misses. The flags held in the flushed slots are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties all slots |
| pt_base | input | MA_W | Word address of page-table entry 0 |
| req_valid | input | 1 | Translation request, held until answered |
| req_vaddr | input | VPN_W+OFF_W | Virtual address |
| req_write | input | 1 | Access is a write |
| resp_valid | output | 1 | Answer present this cycle |
| resp_paddr | output | PFN_W+OFF_W | Physical address |
| resp_fault | output | 1 | Page not present |
| busy | output | 1 | Reload in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | MA_W | Memory word address |
| mem_wdata | output | PFN_W+3 | Written page-table word |
| mem_ack | input | 1 | Memory access complete, read data valid |
| mem_rdata | input | PFN_W+3 | Read page-table word |

## Verification
The assertions assume three things about the inputs. A requester keeps `req_valid`, `req_vaddr` and `req_write` steady until it sees `resp_valid`. `flush` is only pulsed while `busy` is low. The memory acknowledges each access exactly once. The bench's memory model acknowledges one cycle after each request. The bench raises `flush` only between requests. It releases a request only after the edge that follows its answer, so the flag update from a hit always lands before the next access.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_SPILL = 2'd2
  } xlat_state_e;

  localparam int unsigned PTE_PRESENT = 0;
  localparam int unsigned PTE_REF     = 1;
  localparam int unsigned PTE_DIRTY   = 2;
  localparam int unsigned PTE_FRAME   = 3;
endpackage

// File: rtl/xlat_tag_array.sv
module xlat_tag_array #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned VPN_W   = 8,
  parameter int unsigned PFN_W   = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   look_vpn,
  output logic               hit,
  output logic [PFN_W-1:0]   hit_pfn,
  input  logic               touch,
  input  logic               touch_write,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               fill_ref,
  input  logic               fill_dirty,
  input  logic [IDX_W-1:0]   pick_idx,
  output logic [VPN_W-1:0]   pick_vpn,
  output logic [PFN_W-1:0]   pick_pfn,
  output logic               pick_ref,
  output logic               pick_dirty,
  output logic [ENTRIES-1:0] occupied
);
  logic [VPN_W-1:0] vpn_q   [ENTRIES];
  logic [PFN_W-1:0] pfn_q   [ENTRIES];
  logic [ENTRIES-1:0] ref_q, dirty_q, valid_q, match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign match[g] = valid_q[g] && (vpn_q[g] == look_vpn);

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        valid_q[g] <= 1'b0;
        ref_q[g]   <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        ref_q[g]   <= fill_ref;
        dirty_q[g] <= fill_dirty;
      end else if (touch && match[g]) begin
        ref_q[g]   <= 1'b1;
        dirty_q[g] <= dirty_q[g] | touch_write;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_idx == IDX_W'(g)) begin
        vpn_q[g] <= fill_vpn;
        pfn_q[g] <= fill_pfn;
      end
    end
  end

  always_comb begin
    hit_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_pfn = hit_pfn | pfn_q[i];
  end

  assign hit        = |match;
  assign occupied   = valid_q;
  assign pick_vpn   = vpn_q[pick_idx];
  assign pick_pfn   = pfn_q[pick_idx];
  assign pick_ref   = ref_q[pick_idx];
  assign pick_dirty = dirty_q[pick_idx];

  assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
endmodule

// File: rtl/xlat_victim_pick.sv
module xlat_victim_pick #(
  parameter int unsigned ENTRIES = 4,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] occupied,
  input  logic               advance,
  output logic [IDX_W-1:0]   pick_idx,
  output logic               pick_full
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;

  function automatic logic [IDX_W-1:0] step_rr(input logic [IDX_W-1:0] cur);
    return (cur == IDX_W'(ENTRIES - 1)) ? '0 : cur + 1'b1;
  endfunction

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!occupied[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (advance) rr_q <= step_rr(rr_q);
  end

  assign pick_idx  = any_free ? free_idx : rr_q;
  assign pick_full = !any_free;

  assert_free_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(&occupied) |-> !occupied[pick_idx]);
  assert_rr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (rr_q == step_rr($past(rr_q))));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xlat_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned VPN_W   = 8,
  parameter int unsigned PFN_W   = 8,
  parameter int unsigned OFF_W   = 4,
  parameter int unsigned MA_W    = 12,
  localparam int unsigned VA_W   = VPN_W + OFF_W,
  localparam int unsigned PA_W   = PFN_W + OFF_W,
  localparam int unsigned PTE_W  = PFN_W + 3,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [MA_W-1:0]   pt_base,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              resp_fault,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [PTE_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [PTE_W-1:0]  mem_rdata
);
  function automatic logic [PA_W-1:0] join_paddr(input logic [PFN_W-1:0] pfn,
                                                 input logic [OFF_W-1:0] off);
    return {pfn, off};
  endfunction

  function automatic logic [MA_W-1:0] pte_word(input logic [MA_W-1:0] base,
                                               input logic [VPN_W-1:0] vpn);
    return base + MA_W'(vpn);
  endfunction

  function automatic logic [PTE_W-1:0] pack_pte(input logic [PFN_W-1:0] pfn,
                                                input logic dirty, input logic refd);
    return {pfn, dirty, refd, 1'b1};
  endfunction

  xlat_state_e state_q;
  logic [VPN_W-1:0] want_vpn_q;
  logic [PTE_W-1:0] held_pte_q;

  logic [VPN_W-1:0] look_vpn;
  logic [OFF_W-1:0] look_off;
  logic             hit;
  logic [PFN_W-1:0] hit_pfn;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_full;
  logic [VPN_W-1:0] pick_vpn;
  logic [PFN_W-1:0] pick_pfn;
  logic             pick_ref, pick_dirty;
  logic [ENTRIES-1:0] occupied;

  // named internal events
  logic hit_evt, miss_evt, fault_evt, spill_evt, fill_evt, spill_done_evt;
  logic [PTE_W-1:0] fill_pte;

  assign look_vpn = req_vaddr[VA_W-1:OFF_W];
  assign look_off = req_vaddr[OFF_W-1:0];

  assign hit_evt        = (state_q == ST_IDLE) && req_valid && hit && !flush;
  assign miss_evt       = (state_q == ST_IDLE) && req_valid && !hit && !flush;
  assign fault_evt      = (state_q == ST_FETCH) && mem_ack && !mem_rdata[PTE_PRESENT];
  assign spill_evt      = (state_q == ST_FETCH) && mem_ack && mem_rdata[PTE_PRESENT]
                          && pick_full;
  assign spill_done_evt = (state_q == ST_SPILL) && mem_ack;
  assign fill_evt       = ((state_q == ST_FETCH) && mem_ack && mem_rdata[PTE_PRESENT]
                           && !pick_full) || spill_done_evt;
  assign fill_pte       = (state_q == ST_SPILL) ? held_pte_q : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      want_vpn_q <= '0;
      held_pte_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (miss_evt) begin
          state_q    <= ST_FETCH;
          want_vpn_q <= look_vpn;
        end
        ST_FETCH: if (mem_ack) begin
          held_pte_q <= mem_rdata;
          state_q    <= spill_evt ? ST_SPILL : ST_IDLE;
        end
        ST_SPILL: if (mem_ack) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  xlat_tag_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .look_vpn(look_vpn), .hit(hit), .hit_pfn(hit_pfn),
    .touch(hit_evt), .touch_write(req_write),
    .fill_en(fill_evt), .fill_idx(pick_idx), .fill_vpn(want_vpn_q),
    .fill_pfn(fill_pte[PTE_FRAME +: PFN_W]),
    .fill_ref(fill_pte[PTE_REF]), .fill_dirty(fill_pte[PTE_DIRTY]),
    .pick_idx(pick_idx), .pick_vpn(pick_vpn), .pick_pfn(pick_pfn),
    .pick_ref(pick_ref), .pick_dirty(pick_dirty), .occupied(occupied)
  );

  xlat_victim_pick #(.ENTRIES(ENTRIES)) u_pick (
    .clk(clk), .rst_n(rst_n), .occupied(occupied),
    .advance(spill_done_evt), .pick_idx(pick_idx), .pick_full(pick_full)
  );

  assign resp_valid = hit_evt || fault_evt;
  assign resp_fault = fault_evt;
  assign resp_paddr = fault_evt ? '0 : join_paddr(hit_pfn, look_off);
  assign busy       = (state_q != ST_IDLE);
  assign mem_req    = (state_q != ST_IDLE);
  assign mem_we     = (state_q == ST_SPILL);
  assign mem_addr   = (state_q == ST_SPILL) ? pte_word(pt_base, pick_vpn)
                                            : pte_word(pt_base, want_vpn_q);
  assign mem_wdata  = pack_pte(pick_pfn, pick_dirty, pick_ref);

  assert_hit_not_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> !busy);
  assert_fault_keeps_slots_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (occupied == $past(occupied)));
  assert_miss_goes_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (busy && mem_req && !mem_we));
  assert_spill_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (&occupied));
endmodule

// File: tb/test_xlat_buffer.sv
module test_xlat_buffer;
  localparam int unsigned PTE_W = 11;
  localparam logic [11:0] BASE = 12'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic req_valid = 1'b0;
  logic [11:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic resp_valid, resp_fault, busy, mem_req, mem_we;
  logic [11:0] resp_paddr, mem_addr;
  logic [PTE_W-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [PTE_W-1:0] mem_rdata = '0;

  logic [PTE_W-1:0] pt [512];
  int n_checks = 0;
  int n_fail = 0;
  int n_writes = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  xlat_buffer i_xlat_buffer (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(BASE),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // page-table memory: one-cycle acknowledge
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= pt[mem_addr[8:0]];
      if (mem_we) begin
        pt[mem_addr[8:0]] <= mem_wdata;
        n_writes <= n_writes + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      finish_run();
    end
  end

  task automatic access(input logic [11:0] va, input bit wr,
                        output logic [11:0] pa, output bit flt, output bit was_busy);
    int cyc;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr;
    #1;
    cyc = 0; was_busy = 1'b0;
    while (!resp_valid && cyc < 100) begin
      @(negedge clk); #1;
      cyc++;
      if (busy) was_busy = 1'b1;
    end
    pa = resp_paddr; flt = resp_fault;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // frame of page v is 0x40+v for v<8; others not present (R3 layout)
  function automatic logic [PTE_W-1:0] init_pte(input int v);
    return (v < 8) ? {8'(8'h40 + v), 3'b001} : '0;
  endfunction

  // {wr, vaddr, expect miss, expect fault, expected paddr}
  localparam int NV = 12;
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 12'h013, 1'b1, 1'b0, 12'h413},  // R2 miss fills slot 0
    {1'b1, 12'h01A, 1'b0, 1'b0, 12'h41A},  // R1 hit, write sets dirty (R4)
    {1'b0, 12'h022, 1'b1, 1'b0, 12'h422},  // R6 slot 1
    {1'b0, 12'h03F, 1'b1, 1'b0, 12'h43F},  // R6 slot 2
    {1'b1, 12'h045, 1'b1, 1'b0, 12'h445},  // R6 slot 3
    {1'b0, 12'h027, 1'b0, 1'b0, 12'h427},  // R6 nothing evicted
    {1'b0, 12'h03C, 1'b0, 1'b0, 12'h43C},  // R1
    {1'b0, 12'h090, 1'b1, 1'b1, 12'h000},  // R5 not present
    {1'b0, 12'h091, 1'b1, 1'b1, 12'h000},  // R5 still not installed
    {1'b0, 12'h056, 1'b1, 1'b0, 12'h456},  // R7 evicts page 1
    {1'b0, 12'h012, 1'b1, 1'b0, 12'h412},  // R7 evicts page 2
    {1'b0, 12'h048, 1'b0, 1'b0, 12'h448}   // R1 page 4 kept
  };

  initial begin
    logic [11:0] pa;
    bit flt, bz;
    int w0;
    for (int i = 0; i < 512; i++) pt[i] = init_pte(i - 256);
    repeat (3) @(negedge clk);
    check(!busy && !resp_valid && !mem_req, "R2 reset idle", {busy, resp_valid, mem_req}, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      access(VEC[k][25:14], VEC[k][26], pa, flt, bz);
      check(bz == VEC[k][13], $sformatf("R2 vec%0d miss", k), bz, VEC[k][13]);
      check(flt == VEC[k][12], $sformatf("R5 vec%0d fault", k), flt, VEC[k][12]);
      if (!VEC[k][12])
        check(pa == VEC[k][11:0], $sformatf("R1 vec%0d paddr", k), pa, VEC[k][11:0]);
    end

    // write-backs of evicted pages: R4 and R7, R3 layout
    check(pt[9'h101] == 11'h20F, "R4 page1 ref+dirty written back", pt[9'h101], 11'h20F);
    check(pt[9'h102] == 11'h213, "R4 page2 ref only written back", pt[9'h102], 11'h213);
    check(n_writes == 2, "R7 one write per eviction", n_writes, 2);

    // flush: next access misses; dirty page 4 flag dropped (R8)
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    access(12'h048, 1'b0, pa, flt, bz);
    check(bz == 1'b1, "R8 miss after flush", bz, 1);
    check(pa == 12'h448, "R8 paddr after reload", pa, 12'h448);
    w0 = n_writes;
    access(12'h051, 1'b0, pa, flt, bz);
    access(12'h061, 1'b0, pa, flt, bz);
    access(12'h071, 1'b0, pa, flt, bz);
    check(n_writes == w0, "R7 no write into empty slot", n_writes, w0);
    check(pt[9'h104] == 11'h221, "R8 flushed flags dropped", pt[9'h104], 11'h221);
    // full again; round-robin pointer now at slot 2 holding page 6
    access(12'h00B, 1'b1, pa, flt, bz);
    check(pa == 12'h40B && bz, "R2 page0 reload", pa, 12'h40B);
    check(pt[9'h106] == 11'h233, "R7 round-robin victim page6", pt[9'h106], 11'h233);
    access(12'h06B, 1'b0, pa, flt, bz);
    check(bz == 1'b1, "R7 evicted page misses", bz, 1);
    access(12'h04B, 1'b0, pa, flt, bz);
    check(bz == 1'b0 && pa == 12'h44B, "R6 slot0 page survives", pa, 12'h44B);

    finish_run();
  end
endmodule